// File: doc/BRIEF.md
# Trap-Return Privilege State Unit

This block performs the architectural state change that goes with returning from a trap. It handles both the supervisor-level return and the machine-level return. The pipeline raises `req_i` for one cycle and supplies the return type, the current privilege, the virtualization flag, the platform capability flags, both saved exception PCs and the live status bits. One cycle later the unit either pulses `commit_o` or pulses `fault_o` with a cause code.

On a commit, the updated status bits, the new privilege, the new virtualization mode and the return PC appear on registered outputs. They hold those values until the next commit. A return that faults changes none of them. The unit checks its fault conditions in a fixed order and reports only the first one that applies.

Privilege encoding is U=0, S=1, M=3; the value 2 is treated as a level at or above S and below M. Fault cause codes are 0 for a misaligned return address, 1 for an instruction access fault, 2 for an illegal instruction and 22 for a virtual-instruction fault.

Top module: `trapret_unit`

## Requirements
- R1: In the cycle after a `req_i` pulse, exactly one of `commit_o` or `fault_o` is high. Both are low in the cycle after any cycle without `req_i`.
- R2: A supervisor return (`is_mret_i`=0) issued at privilege U (0) faults with code 2. This check takes precedence over every other check.
- R3: When `rvc_i`=0 and bits [1:0] of the selected return PC are nonzero, the return faults with code 0. The selected PC is `sepc_i` for a supervisor return and `mepc_i` for a machine return. This check comes right after the privilege check.
- R4: After R3, a supervisor return faults with code 2 if `tsr_i`=1 and the privilege is not M. Failing that, it faults with code 22 if `virt_i`=1 and `vtsr_i`=1.
- R5: A committed supervisor return has these effects:
  - SIE takes the old SPIE.
  - SPIE becomes 1.
  - SPP becomes 0 (U).
  - `priv_o` becomes {0, old SPP}.
  - `ret_pc_o` becomes `sepc_i`.
  - MIE, MPIE, MPP and MPV are unchanged.
- R6: When `ver112_i`=1, a committed supervisor return clears MPRV. A committed machine return clears MPRV only when the old MPP is not M. In every other case MPRV keeps its input value.
- R7: On a committed supervisor return with `hyp_i`=1 and `virt_i`=0, `virt_o` takes SPV and SPV becomes 0. Otherwise `virt_o` equals `virt_i` and SPV is unchanged.
- R8: A committed machine return has these effects:
  - MIE takes the old MPIE.
  - MPIE becomes 1.
  - MPP becomes 0 if `umode_i`=1, else 3.
  - MPV becomes 0.
  - `priv_o` becomes the old MPP.
  - `ret_pc_o` becomes `mepc_i`.
  - SIE, SPIE, SPP and SPV are unchanged.
- R9: On a committed machine return with `hyp_i`=1, `virt_o` = MPV AND (old MPP is not M). With `hyp_i`=0, `virt_o` equals `virt_i`.
- R10: A machine return issued at any privilege other than M faults with code 2. This check comes first.
- R11: After R3, a machine return faults with code 1 when all of the following hold: `pmp_impl_i`=1, `pmp_has_rules_i`=0, and the old MPP is not M.
- R12: A faulting return leaves every registered state output unchanged. After reset all state outputs are 0, except `priv_o`, which is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle return request |
| is_mret_i | input | 1 | 1 = machine return, 0 = supervisor return |
| priv_i | input | 2 | Current privilege |
| virt_i | input | 1 | Virtualization currently on |
| rvc_i | input | 1 | Compressed instructions supported |
| umode_i | input | 1 | U mode implemented |
| hyp_i | input | 1 | Hypervisor support present |
| ver112_i | input | 1 | Privileged spec version 1.12 or later |
| pmp_impl_i | input | 1 | Physical memory protection implemented |
| pmp_has_rules_i | input | 1 | At least one protection rule configured |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| mepc_i | input | XLEN | Saved machine exception PC |
| sie_i | input | 1 | Supervisor interrupt enable |
| spie_i | input | 1 | Supervisor previous interrupt enable |
| spp_i | input | 1 | Supervisor previous privilege |
| mie_i | input | 1 | Machine interrupt enable |
| mpie_i | input | 1 | Machine previous interrupt enable |
| mpp_i | input | 2 | Machine previous privilege |
| mpv_i | input | 1 | Machine previous virtualization |
| mprv_i | input | 1 | Modify-privilege bit |
| tsr_i | input | 1 | Trap supervisor return |
| spv_i | input | 1 | Hypervisor supervisor previous virtualization |
| vtsr_i | input | 1 | Trap supervisor return while virtualized |
| commit_o | output | 1 | Return committed |
| fault_o | output | 1 | Return faulted |
| fault_code_o | output | 5 | Fault cause code |
| sie_o | output | 1 | Updated SIE |
| spie_o | output | 1 | Updated SPIE |
| spp_o | output | 1 | Updated SPP |
| mie_o | output | 1 | Updated MIE |
| mpie_o | output | 1 | Updated MPIE |
| mpp_o | output | 2 | Updated MPP |
| mpv_o | output | 1 | Updated MPV |
| mprv_o | output | 1 | Updated MPRV |
| spv_o | output | 1 | Updated SPV |
| priv_o | output | 2 | New privilege |
| virt_o | output | 1 | New virtualization mode |
| ret_pc_o | output | XLEN | Return PC |

## Verification
A wrong priority in the fault chain shows up as the wrong cause code. It appears one cycle after a request in which two conditions hold at once, for example a misaligned PC together with TSR, or a user-level request together with an empty protection table. A wrong stack pop or MPRV rule shows up in the status outputs on that same commit cycle. A write that leaks through on a faulting return shows up at the fault pulse as a changed state output. The bench compares every output after every request against a shadow model, so any such divergence is reported one cycle after the request that caused it.

// File: rtl/trapret_pkg.sv
package trapret_pkg;
  localparam int unsigned FC_W = 5;
  localparam int unsigned PRIV_W = 2;

  localparam logic [PRIV_W-1:0] PRIV_U = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_S = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;

  localparam logic [FC_W-1:0] FC_MISALIGN = 5'd0;
  localparam logic [FC_W-1:0] FC_ACCESS   = 5'd1;
  localparam logic [FC_W-1:0] FC_ILLEGAL  = 5'd2;
  localparam logic [FC_W-1:0] FC_VIRT     = 5'd22;

  typedef struct packed {
    logic              sie;
    logic              spie;
    logic              spp;
    logic              mie;
    logic              mpie;
    logic [PRIV_W-1:0] mpp;
    logic              mpv;
    logic              mprv;
    logic              spv;
  } stat_t;
endpackage

// File: rtl/trapret_fault.sv
module trapret_fault
  import trapret_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic                is_mret_i,
  input  logic [PRIV_W-1:0]   priv_i,
  input  logic                virt_i,
  input  logic                rvc_i,
  input  logic                tsr_i,
  input  logic                vtsr_i,
  input  logic [PRIV_W-1:0]   mpp_i,
  input  logic                pmp_impl_i,
  input  logic                pmp_has_rules_i,
  input  logic [XLEN-1:0]     pc_i,
  output logic                fault_o,
  output logic [FC_W-1:0]     code_o
);
  logic misalign;

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign misalign = !rvc_i && (|pc_i[ALIGN_BITS-1:0]);
    end else begin : g_noalign
      assign misalign = 1'b0;
    end
  endgenerate

  always_comb begin
    fault_o = 1'b0;
    code_o  = FC_MISALIGN;
    if (is_mret_i) begin
      if (priv_i != PRIV_M) begin
        fault_o = 1'b1; code_o = FC_ILLEGAL;
      end else if (misalign) begin
        fault_o = 1'b1; code_o = FC_MISALIGN;
      end else if (pmp_impl_i && !pmp_has_rules_i && (mpp_i != PRIV_M)) begin
        fault_o = 1'b1; code_o = FC_ACCESS;
      end
    end else begin
      if (priv_i == PRIV_U) begin
        fault_o = 1'b1; code_o = FC_ILLEGAL;
      end else if (misalign) begin
        fault_o = 1'b1; code_o = FC_MISALIGN;
      end else if (tsr_i && (priv_i != PRIV_M)) begin
        fault_o = 1'b1; code_o = FC_ILLEGAL;
      end else if (virt_i && vtsr_i) begin
        fault_o = 1'b1; code_o = FC_VIRT;
      end
    end
  end
endmodule

// File: rtl/trapret_next.sv
module trapret_next
  import trapret_pkg::*;
(
  input  logic                is_mret_i,
  input  logic                virt_i,
  input  logic                umode_i,
  input  logic                hyp_i,
  input  logic                ver112_i,
  input  stat_t               stat_i,
  output stat_t               stat_o,
  output logic [PRIV_W-1:0]   priv_o,
  output logic                virt_o
);
  logic mpp_not_m;
  assign mpp_not_m = (stat_i.mpp != PRIV_M);

  always_comb begin
    stat_o = stat_i;
    virt_o = virt_i;
    if (is_mret_i) begin
      priv_o      = stat_i.mpp;
      stat_o.mie  = stat_i.mpie;
      stat_o.mpie = 1'b1;
      stat_o.mpp  = umode_i ? PRIV_U : PRIV_M;
      stat_o.mpv  = 1'b0;
      if (ver112_i && mpp_not_m) stat_o.mprv = 1'b0;
      if (hyp_i) virt_o = stat_i.mpv && mpp_not_m;
    end else begin
      priv_o      = {1'b0, stat_i.spp};
      stat_o.sie  = stat_i.spie;
      stat_o.spie = 1'b1;
      stat_o.spp  = 1'b0;
      if (ver112_i) stat_o.mprv = 1'b0;
      if (hyp_i && !virt_i) begin
        virt_o     = stat_i.spv;
        stat_o.spv = 1'b0;
      end
    end
  end
endmodule

// File: rtl/trapret_unit.sv
module trapret_unit
  import trapret_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              is_mret_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic              rvc_i,
  input  logic              umode_i,
  input  logic              hyp_i,
  input  logic              ver112_i,
  input  logic              pmp_impl_i,
  input  logic              pmp_has_rules_i,
  input  logic [XLEN-1:0]   sepc_i,
  input  logic [XLEN-1:0]   mepc_i,
  input  logic              sie_i,
  input  logic              spie_i,
  input  logic              spp_i,
  input  logic              mie_i,
  input  logic              mpie_i,
  input  logic [1:0]        mpp_i,
  input  logic              mpv_i,
  input  logic              mprv_i,
  input  logic              tsr_i,
  input  logic              spv_i,
  input  logic              vtsr_i,
  output logic              commit_o,
  output logic              fault_o,
  output logic [4:0]        fault_code_o,
  output logic              sie_o,
  output logic              spie_o,
  output logic              spp_o,
  output logic              mie_o,
  output logic              mpie_o,
  output logic [1:0]        mpp_o,
  output logic              mpv_o,
  output logic              mprv_o,
  output logic              spv_o,
  output logic [1:0]        priv_o,
  output logic              virt_o,
  output logic [XLEN-1:0]   ret_pc_o
);
  stat_t             stat_in, stat_nxt, stat_q;
  logic [PRIV_W-1:0] priv_nxt, priv_q;
  logic              virt_nxt, virt_q;
  logic [XLEN-1:0]   pc_sel, pc_q;
  logic              chk_fault;
  logic [FC_W-1:0]   chk_code;

  assign stat_in = '{sie: sie_i, spie: spie_i, spp: spp_i, mie: mie_i,
                     mpie: mpie_i, mpp: mpp_i, mpv: mpv_i, mprv: mprv_i,
                     spv: spv_i};
  assign pc_sel = is_mret_i ? mepc_i : sepc_i;

  trapret_fault #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_fault (
    .is_mret_i       (is_mret_i),
    .priv_i          (priv_i),
    .virt_i          (virt_i),
    .rvc_i           (rvc_i),
    .tsr_i           (tsr_i),
    .vtsr_i          (vtsr_i),
    .mpp_i           (mpp_i),
    .pmp_impl_i      (pmp_impl_i),
    .pmp_has_rules_i (pmp_has_rules_i),
    .pc_i            (pc_sel),
    .fault_o         (chk_fault),
    .code_o          (chk_code)
  );

  trapret_next u_next (
    .is_mret_i (is_mret_i),
    .virt_i    (virt_i),
    .umode_i   (umode_i),
    .hyp_i     (hyp_i),
    .ver112_i  (ver112_i),
    .stat_i    (stat_in),
    .stat_o    (stat_nxt),
    .priv_o    (priv_nxt),
    .virt_o    (virt_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o     <= 1'b0;
      fault_o      <= 1'b0;
      fault_code_o <= '0;
    end else begin
      commit_o <= req_i && !chk_fault;
      fault_o  <= req_i && chk_fault;
      if (req_i && chk_fault) fault_code_o <= chk_code;
    end
  end

  // architectural state only moves on a clean return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      priv_q <= PRIV_M;
      virt_q <= 1'b0;
      pc_q   <= '0;
    end else if (req_i && !chk_fault) begin
      stat_q <= stat_nxt;
      priv_q <= priv_nxt;
      virt_q <= virt_nxt;
      pc_q   <= pc_sel;
    end
  end

  assign sie_o    = stat_q.sie;
  assign spie_o   = stat_q.spie;
  assign spp_o    = stat_q.spp;
  assign mie_o    = stat_q.mie;
  assign mpie_o   = stat_q.mpie;
  assign mpp_o    = stat_q.mpp;
  assign mpv_o    = stat_q.mpv;
  assign mprv_o   = stat_q.mprv;
  assign spv_o    = stat_q.spv;
  assign priv_o   = priv_q;
  assign virt_o   = virt_q;
  assign ret_pc_o = pc_q;

  assert_one_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (commit_o ^ fault_o));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(commit_o || fault_o));
  assert_user_sret_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !is_mret_i && priv_i == PRIV_U) |=> (fault_o && fault_code_o == FC_ILLEGAL));
  assert_mret_priv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_mret_i && priv_i != PRIV_M) |=> (fault_o && fault_code_o == FC_ILLEGAL));
  assert_sret_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !is_mret_i) |=> (!commit_o || (spie_o && !spp_o)));
  assert_mret_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_mret_i) |=> (!commit_o || (mpie_o && !mpv_o)));
  assert_fault_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($stable(stat_q) && $stable(priv_q) && $stable(virt_q) && $stable(pc_q)));
endmodule

// File: tb/trapret_unit_tb_top.sv
`timescale 1ns/1ps
module trapret_unit_tb_top;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req = 0, is_mret = 0, virt = 0, rvc = 1, umode = 1, hyp = 0, ver112 = 0;
  logic pmp_impl = 0, pmp_rules = 1;
  logic [1:0] priv = 2'd3;
  logic [XLEN-1:0] sepc = '0, mepc = '0;
  logic sie = 0, spie = 0, spp = 0, mie = 0, mpie = 0, mpv = 0, mprv = 0, tsr = 0, spv = 0, vtsr = 0;
  logic [1:0] mpp = 2'd0;

  logic commit, fault, sie_q, spie_q, spp_q, mie_q, mpie_q, mpv_q, mprv_q, spv_q, virt_q;
  logic [4:0] code;
  logic [1:0] mpp_q, priv_q;
  logic [XLEN-1:0] pc_q;

  trapret_unit #(.XLEN(XLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .is_mret_i(is_mret), .priv_i(priv),
    .virt_i(virt), .rvc_i(rvc), .umode_i(umode), .hyp_i(hyp), .ver112_i(ver112),
    .pmp_impl_i(pmp_impl), .pmp_has_rules_i(pmp_rules), .sepc_i(sepc), .mepc_i(mepc),
    .sie_i(sie), .spie_i(spie), .spp_i(spp), .mie_i(mie), .mpie_i(mpie), .mpp_i(mpp),
    .mpv_i(mpv), .mprv_i(mprv), .tsr_i(tsr), .spv_i(spv), .vtsr_i(vtsr),
    .commit_o(commit), .fault_o(fault), .fault_code_o(code),
    .sie_o(sie_q), .spie_o(spie_q), .spp_o(spp_q), .mie_o(mie_q), .mpie_o(mpie_q),
    .mpp_o(mpp_q), .mpv_o(mpv_q), .mprv_o(mprv_q), .spv_o(spv_q), .priv_o(priv_q),
    .virt_o(virt_q), .ret_pc_o(pc_q)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // shadow of the registered outputs
  logic e_sie = 0, e_spie = 0, e_spp = 0, e_mie = 0, e_mpie = 0, e_mpv = 0, e_mprv = 0, e_spv = 0, e_virt = 0;
  logic [1:0] e_mpp = 0, e_priv = 2'd3;
  logic [XLEN-1:0] e_pc = '0;
  logic e_fault;
  logic [4:0] e_code;
  string e_tag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model();
    logic [XLEN-1:0] pc;
    logic mis;
    pc = is_mret ? mepc : sepc;
    mis = !rvc && (pc[1:0] != 2'b00);
    e_fault = 1; e_code = 0;
    if (is_mret) begin
      if (priv != 2'd3) begin e_code = 2; e_tag = "R10"; end
      else if (mis) begin e_code = 0; e_tag = "R3"; end
      else if (pmp_impl && !pmp_rules && mpp != 2'd3) begin e_code = 1; e_tag = "R11"; end
      else e_fault = 0;
    end else begin
      if (priv == 2'd0) begin e_code = 2; e_tag = "R2"; end
      else if (mis) begin e_code = 0; e_tag = "R3"; end
      else if (tsr && priv != 2'd3) begin e_code = 2; e_tag = "R4"; end
      else if (virt && vtsr) begin e_code = 22; e_tag = "R4"; end
      else e_fault = 0;
    end
    if (!e_fault) begin
      e_sie = sie; e_spie = spie; e_spp = spp; e_mie = mie; e_mpie = mpie;
      e_mpp = mpp; e_mpv = mpv; e_mprv = mprv; e_spv = spv; e_virt = virt; e_pc = pc;
      if (is_mret) begin
        e_tag = "R8";
        e_priv = mpp; e_mie = mpie; e_mpie = 1; e_mpp = umode ? 2'd0 : 2'd3; e_mpv = 0;
        if (ver112 && mpp != 2'd3) e_mprv = 0;
        if (hyp) e_virt = mpv && (mpp != 2'd3);
      end else begin
        e_tag = "R5";
        e_priv = {1'b0, spp}; e_sie = spie; e_spie = 1; e_spp = 0;
        if (ver112) e_mprv = 0;
        if (hyp && !virt) begin e_virt = spv; e_spv = 0; end
      end
    end
  endtask

  task automatic check_state(input string tag);
    chk(sie_q == e_sie && spie_q == e_spie && spp_q == e_spp, tag, "s-stack",
        {sie_q, spie_q, spp_q}, {e_sie, e_spie, e_spp});
    chk(mie_q == e_mie && mpie_q == e_mpie && mpp_q == e_mpp && mpv_q == e_mpv, tag, "m-stack",
        {mie_q, mpie_q, mpp_q, mpv_q}, {e_mie, e_mpie, e_mpp, e_mpv});
    chk(priv_q == e_priv, tag, "priv", priv_q, e_priv);
    chk(pc_q == e_pc, tag, "ret_pc", pc_q, e_pc);
    chk(mprv_q == e_mprv, e_fault ? tag : "R6", "mprv", mprv_q, e_mprv);
    chk(virt_q == e_virt && spv_q == e_spv, e_fault ? tag : (is_mret ? "R9" : "R7"),
        "virt/spv", {virt_q, spv_q}, {e_virt, e_spv});
  endtask

  task automatic issue();
    @(negedge clk);
    req = 1;
    model();
    @(negedge clk);
    req = 0;
    chk(commit == !e_fault && fault == e_fault, "R1", "strobes", {commit, fault}, {!e_fault, e_fault});
    if (e_fault) chk(code == e_code, e_tag, "code", code, e_code);
    check_state(e_fault ? "R12" : e_tag);
    @(negedge clk);
    chk(!commit && !fault, "R1", "idle strobes", {commit, fault}, 0);
  endtask

  task automatic clean();
    virt = 0; rvc = 1; umode = 1; hyp = 0; ver112 = 0; pmp_impl = 0; pmp_rules = 1;
    tsr = 0; vtsr = 0; sepc = 64'h1000; mepc = 64'h2000;
    sie = 0; spie = 1; spp = 1; mie = 0; mpie = 1; mpp = 2'd1; mpv = 1; mprv = 1; spv = 1;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R12 reset state
    check_state("R12");
    chk(!commit && !fault, "R12", "reset strobes", {commit, fault}, 0);
    rst_n = 1;
    @(negedge clk);

    // directed: R5 plain sret from S
    clean(); is_mret = 0; priv = 2'd1; issue();
    // R2 user sret beats misalignment and TSR
    clean(); priv = 2'd0; rvc = 0; sepc = 64'h1002; tsr = 1; issue();
    // R3 misaligned sret beats TSR
    clean(); priv = 2'd1; rvc = 0; sepc = 64'h1001; tsr = 1; issue();
    // R4 TSR then VTSR
    clean(); priv = 2'd1; tsr = 1; virt = 1; vtsr = 1; issue();
    clean(); priv = 2'd3; tsr = 1; virt = 1; vtsr = 1; issue();
    // R7 hypervisor restore, R6 mprv cleared
    clean(); priv = 2'd1; hyp = 1; ver112 = 1; issue();
    clean(); priv = 2'd3; hyp = 1; virt = 1; spv = 1; issue();
    // R10 mret from S
    clean(); is_mret = 1; priv = 2'd1; issue();
    // R8/R9 mret committing, with and without U mode
    clean(); is_mret = 1; priv = 2'd3; hyp = 1; ver112 = 1; issue();
    clean(); is_mret = 1; priv = 2'd3; umode = 0; mpp = 2'd3; hyp = 1; ver112 = 1; issue();
    // R11 empty protection table; R3 first
    clean(); is_mret = 1; priv = 2'd3; pmp_impl = 1; pmp_rules = 0; issue();
    clean(); is_mret = 1; priv = 2'd3; pmp_impl = 1; pmp_rules = 0; rvc = 0; mepc = 64'h2002; issue();
    clean(); is_mret = 1; priv = 2'd3; pmp_impl = 1; pmp_rules = 0; mpp = 2'd3; issue();
    // rvc allows odd halfword PC
    clean(); is_mret = 1; priv = 2'd3; mepc = 64'h2002; issue();

    for (int i = 0; i < 400; i++) begin
      logic [1:0] pick;
      is_mret = $urandom_range(0, 1);
      pick = 2'($urandom_range(0, 3)); priv = (pick == 2'd2) ? 2'd3 : pick;
      pick = 2'($urandom_range(0, 3)); mpp = (pick == 2'd2) ? 2'd0 : pick;
      virt = $urandom_range(0, 1); rvc = ($urandom_range(0, 3) != 0);
      umode = $urandom_range(0, 1); hyp = $urandom_range(0, 1); ver112 = $urandom_range(0, 1);
      pmp_impl = $urandom_range(0, 1); pmp_rules = ($urandom_range(0, 3) != 0);
      tsr = ($urandom_range(0, 3) == 0); vtsr = ($urandom_range(0, 3) == 0);
      sepc = {$urandom, $urandom}; mepc = {$urandom, $urandom};
      if ($urandom_range(0, 1)) begin sepc[1:0] = 0; mepc[1:0] = 0; end
      sie = $urandom_range(0, 1); spie = $urandom_range(0, 1); spp = $urandom_range(0, 1);
      mie = $urandom_range(0, 1); mpie = $urandom_range(0, 1); mpv = $urandom_range(0, 1);
      mprv = $urandom_range(0, 1); spv = $urandom_range(0, 1);
      issue();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule